// File: doc/BRIEF.md
# I2C Bus Master Phase Sequencer

This block is a single-master I2C controller that runs one bus phase for each command pulse. Five commands are available: Start, byte transmit (launched by writing the data buffer), byte receive, acknowledge, and Stop. While a phase runs, the matching bit of a five-bit activity vector is high. The bit drops when the phase finishes, and in that same cycle the interrupt flag rises.

Between phases the master holds SCL low, so software or a higher-level sequencer can issue the next command whenever it is ready. Both bus lines are open-drain. The block drives only pull-low enables and reads back the resolved line levels.

Each SCL half period lasts (div_i+1) system clocks. The high-half counter starts only once SCL is actually seen high. As a result, a slave that stretches the clock always gets a full-width high pulse after it releases the line.

Top module: `i2c_cmd_master`

## Requirements
- R1: When start_i is pulsed while idle, the master pulls SDA low with SCL released for one half period, then pulls SCL low for one half period. After that, active_o[0] clears, irq_o sets, and both lines stay pulled low.
- R2: When wr_i is pulsed between phases, wdata_i is sent MSB first over 8 clocks. Each bit is placed on SDA while SCL is low. On the 9th clock SDA is released, and the SDA level seen at the end of that high half is stored in nack_o (0 = acknowledged, 1 = not acknowledged). irq_o then sets.
- R3: When rcv_i is pulsed between phases, 8 bits are clocked in with SDA released. Each bit is sampled at the end of its SCL high half, first bit into the MSB. The byte goes to rdata_o, buf_full_o sets, irq_o sets and active_o[2] clears.
- R4: If a received byte completes while buf_full_o is still 1, ovf_o sets and rdata_o keeps its old byte.
- R5: When ack_i is pulsed between phases, the master drives SDA to ack_val_i (0 = pull low, 1 = release) for one SCL clock. The level is held afterwards until the next phase, and irq_o sets at the end.
- R6: When stop_i is pulsed between phases, the master pulls SDA low while SCL is low. It then releases SCL, waits a high half period, and releases SDA for one more half period. After that, stop_seen_o and irq_o set and both lines are released (idle).
- R7: Every SCL low half and high half lasts div_i+1 clocks. The high-half count only starts, and only advances, while scl_i reads 1. So after a slave holds SCL low, the master's high half is still full width.
- R8: A command is ignored and wcol_o is set in any of these cases: start_i arrives when the bus is not idle; wr_i, rcv_i, ack_i or stop_i arrives when the master is not waiting between phases; or more than one command arrives in the same cycle.
- R9: After reset, every output is 0. A clr_i pulse clears irq_o, ovf_o, wcol_o and stop_seen_o. An rd_i pulse clears buf_full_o. A flag being set wins over a clear in the same cycle.
- R10: active_o is never more than one-hot. Its bit is set by the edge that accepts a command and cleared by the edge that ends that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Half-period length minus one, in clocks |
| start_i | input | 1 | Start command pulse |
| wr_i | input | 1 | Buffer write pulse, launches a byte transmit |
| wdata_i | input | DW | Byte to transmit |
| rcv_i | input | 1 | Receive command pulse |
| ack_i | input | 1 | Acknowledge command pulse |
| ack_val_i | input | 1 | Level to send in the acknowledge clock |
| stop_i | input | 1 | Stop command pulse |
| rd_i | input | 1 | Buffer read pulse, clears buffer-full |
| clr_i | input | 1 | Clears irq, overflow, collision and stop flags |
| scl_i | input | 1 | Resolved SCL level, synchronous to clk_i |
| sda_i | input | 1 | Resolved SDA level, synchronous to clk_i |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| rdata_o | output | DW | Receive buffer |
| irq_o | output | 1 | Phase-complete flag |
| buf_full_o | output | 1 | Receive buffer holds an unread byte |
| ovf_o | output | 1 | Byte received while buffer full |
| stop_seen_o | output | 1 | Stop condition completed |
| wcol_o | output | 1 | Command rejected |
| nack_o | output | 1 | Slave level on the last transmit's 9th clock |
| active_o | output | 5 | One-hot running phase: start, tx, rx, ack, stop |

## Verification
The command-accepting edge drives the pad enables for the first half period, so the new line levels are visible one cycle after the command pulse. Each later half period ends on the edge where div_i+1 counted clocks have elapsed. During a stretch the high half counts no clocks. The completion flags, rdata_o and nack_o change on the same edge that ends the last half period. The bench model steps a queue of half-period segments in the same way and compares all outputs at the falling clock edge after every rising edge. That is where each of these registered results first becomes valid.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_START, ST_BIT, ST_STOP} st_e;
  typedef enum logic [1:0] {MD_TX, MD_RX, MD_ACK} md_e;
  localparam int unsigned CMD_N   = 5;
  localparam int unsigned C_START = 0;
  localparam int unsigned C_TX    = 1;
  localparam int unsigned C_RX    = 2;
  localparam int unsigned C_ACK   = 3;
  localparam int unsigned C_STOP  = 4;
endpackage

// File: rtl/i2cm_timer.sv
module i2cm_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wait_high_i,
  input  logic             scl_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             adv;

  // high halves only count while the line is really high
  assign adv    = run_i & (~wait_high_i | scl_i);
  assign tick_o = adv & (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (adv)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cm_shifter.sv
module i2cm_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          shift_i,
  input  logic          in_bit_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= load_data_i;
    else if (shift_i) q_o <= {q_o[DW-2:0], in_bit_i};
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2cm_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rcv_i,
  input  logic             ack_i,
  input  logic             ack_val_i,
  input  logic             stop_i,
  input  logic             rd_i,
  input  logic             clr_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o,
  output logic             buf_full_o,
  output logic             ovf_o,
  output logic             stop_seen_o,
  output logic             wcol_o,
  output logic             nack_o,
  output logic [CMD_N-1:0] active_o
);
  localparam int unsigned     BC_W    = $clog2(DW + 2);
  localparam logic [BC_W-1:0] LAST_TX = BC_W'(DW);
  localparam logic [BC_W-1:0] LAST_RX = BC_W'(DW - 1);

  st_e             st_q;
  md_e             mode_q;
  logic [1:0]      step_q;
  logic [BC_W-1:0] bit_q;
  logic            ack_val_q;
  logic            sda_hold_q;

  logic [CMD_N-1:0] req;
  logic             multi, accept, wcol_set;
  logic             tick, run, wait_high, last_step, done, shift_en;
  logic             bit_low;
  logic [BC_W-1:0]  last_idx;
  logic [DW-1:0]    sh_q, rx_byte;
  logic             done_rx, done_tx, done_stop;

  assign req      = {stop_i, ack_i, rcv_i, wr_i, start_i};
  assign multi    = |(req & (req - CMD_N'(1)));
  assign accept   = (|req) & ~multi &
                    (req[C_START] ? (st_q == ST_IDLE) : (st_q == ST_HOLD));
  assign wcol_set = (|req) & ~accept;

  assign run       = (st_q == ST_START) | (st_q == ST_BIT) | (st_q == ST_STOP);
  assign wait_high = ((st_q == ST_BIT) | (st_q == ST_STOP)) & (step_q == 2'd1);
  assign shift_en  = tick & (st_q == ST_BIT) & (step_q == 2'd1);
  assign rx_byte   = {sh_q[DW-2:0], sda_i};

  i2cm_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .wait_high_i(wait_high),
    .scl_i(scl_i), .div_i(div_i), .tick_o(tick)
  );

  i2cm_shifter #(.DW(DW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept & req[C_TX]),
    .load_data_i(wdata_i), .shift_i(shift_en), .in_bit_i(sda_i), .q_o(sh_q)
  );

  always_comb begin
    case (mode_q)
      MD_TX:   begin bit_low = (bit_q < LAST_TX) ? ~sh_q[DW-1] : 1'b0; last_idx = LAST_TX; end
      MD_RX:   begin bit_low = 1'b0;        last_idx = LAST_RX; end
      default: begin bit_low = ~ack_val_q;  last_idx = '0;      end
    endcase
  end

  always_comb begin
    scl_oe_o  = 1'b0;
    sda_oe_o  = 1'b0;
    last_step = 1'b0;
    case (st_q)
      ST_HOLD:  begin scl_oe_o = 1'b1; sda_oe_o = sda_hold_q; end
      ST_START: begin
        scl_oe_o  = (step_q == 2'd1);
        sda_oe_o  = 1'b1;
        last_step = (step_q == 2'd1);
      end
      ST_BIT: begin
        scl_oe_o  = (step_q == 2'd0);
        sda_oe_o  = bit_low;
        last_step = (step_q == 2'd1) & (bit_q == last_idx);
      end
      ST_STOP: begin
        scl_oe_o  = (step_q == 2'd0);
        sda_oe_o  = (step_q != 2'd2);
        last_step = (step_q == 2'd2);
      end
      default: ;
    endcase
  end

  assign done      = tick & last_step;
  assign done_rx   = done & (st_q == ST_BIT) & (mode_q == MD_RX);
  assign done_tx   = done & (st_q == ST_BIT) & (mode_q == MD_TX);
  assign done_stop = done & (st_q == ST_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mode_q     <= MD_TX;
      step_q     <= '0;
      bit_q      <= '0;
      ack_val_q  <= 1'b0;
      sda_hold_q <= 1'b0;
      active_o   <= '0;
    end else if (accept) begin
      active_o <= req;
      step_q   <= '0;
      bit_q    <= '0;
      if (req[C_START])     st_q <= ST_START;
      else if (req[C_STOP]) st_q <= ST_STOP;
      else begin
        st_q <= ST_BIT;
        if (req[C_TX])      mode_q <= MD_TX;
        else if (req[C_RX]) mode_q <= MD_RX;
        else begin
          mode_q    <= MD_ACK;
          ack_val_q <= ack_val_i;
        end
      end
    end else if (done) begin
      active_o   <= '0;
      step_q     <= '0;
      st_q       <= (st_q == ST_STOP) ? ST_IDLE : ST_HOLD;
      sda_hold_q <= sda_oe_o;
    end else if (tick) begin
      if (st_q == ST_BIT && step_q == 2'd1) begin
        step_q <= 2'd0;
        bit_q  <= bit_q + 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o       <= 1'b0;
      ovf_o       <= 1'b0;
      wcol_o      <= 1'b0;
      stop_seen_o <= 1'b0;
      buf_full_o  <= 1'b0;
      nack_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      if (done)           irq_o <= 1'b1;
      else if (clr_i)     irq_o <= 1'b0;
      if (done_rx && buf_full_o) ovf_o <= 1'b1;
      else if (clr_i)     ovf_o <= 1'b0;
      if (wcol_set)       wcol_o <= 1'b1;
      else if (clr_i)     wcol_o <= 1'b0;
      if (done_stop)      stop_seen_o <= 1'b1;
      else if (clr_i)     stop_seen_o <= 1'b0;
      if (done_rx)        buf_full_o <= 1'b1;
      else if (rd_i)      buf_full_o <= 1'b0;
      if (done_rx && !buf_full_o) rdata_o <= rx_byte;
      if (done_tx)        nack_o <= sda_i;
    end
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          rd_i,
  input logic          scl_i,
  input logic          scl_oe_o,
  input logic          sda_oe_o,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input logic          buf_full_o,
  input logic          ovf_o,
  input logic          stop_seen_o,
  input logic          wcol_o,
  input logic [4:0]    active_o
);
  a_r10_active_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(active_o));

  a_r1_sda_before_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o[0] && !scl_oe_o) |-> sda_oe_o);

  a_r8_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|active_o) && start_i) |=> wcol_o);

  a_r7_wait_for_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|active_o[4:1]) && !scl_oe_o && !scl_i) |=> !scl_oe_o);

  a_r4_ovf_keeps_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $stable(rdata_o));

  a_r6_stop_leaves_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_seen_o) |-> (!scl_oe_o && !sda_oe_o));

  a_r9_read_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !active_o[2]) |=> !buf_full_o);

  a_r3_full_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_full_o) |-> irq_o);
endmodule

bind i2c_cmd_master i2cm_checker #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rd_i(rd_i), .scl_i(scl_i),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .rdata_o(rdata_o), .irq_o(irq_o),
  .buf_full_o(buf_full_o), .ovf_o(ovf_o), .stop_seen_o(stop_seen_o),
  .wcol_o(wcol_o), .active_o(active_o)
);

// File: tb/tb_i2c_cmd_master.sv
`timescale 1ns/1ps
module tb_i2c_cmd_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] div_r = 8'd3;
  logic start_r = 0, wr_r = 0, rcv_r = 0, ack_r = 0, ack_val_r = 0, stop_r = 0, rd_r = 0, clr_r = 0;
  logic [7:0] wdata_r = 0;
  logic sl_scl_hold = 0, sl_sda_low = 0;

  wire scl_oe_w, sda_oe_w, irq_w, bf_w, ovf_w, stop_w, wcol_w, nack_w;
  wire [7:0] rdata_w;
  wire [4:0] active_w;
  wire scl_line = !(scl_oe_w || sl_scl_hold);
  wire sda_line = !(sda_oe_w || sl_sda_low);

  i2c_cmd_master dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_r), .start_i(start_r), .wr_i(wr_r),
    .wdata_i(wdata_r), .rcv_i(rcv_r), .ack_i(ack_r), .ack_val_i(ack_val_r),
    .stop_i(stop_r), .rd_i(rd_r), .clr_i(clr_r), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe_w), .sda_oe_o(sda_oe_w), .rdata_o(rdata_w), .irq_o(irq_w),
    .buf_full_o(bf_w), .ovf_o(ovf_w), .stop_seen_o(stop_w), .wcol_o(wcol_w),
    .nack_o(nack_w), .active_o(active_w)
  );

  int checks = 0, fails = 0;
  string cur_req = "R9";
  bit finished = 0;

  // slave model
  logic [8:0] sl_pat = 9'h1FF;
  int  sl_rc = 9, sl_stretch_n = 0, stretch_left = 0;
  bit  sl_armed = 0, prev_line = 1, prev_scl_oe = 0;

  // behavioural reference: queue of half-period segments
  // segment bits: 0 scl_oe, 1 sda_oe, 2 waits for scl high, 3 samples sda at end
  int  mq[$];
  int  m_cnt = 0, m_kind = 0;
  bit  m_busy = 0, m_idle = 1, m_sda_hold = 0;
  bit  m_irq = 0, m_bf = 0, m_ovf = 0, m_stop = 0, m_wcol = 0, m_nack = 0;
  logic [4:0]  m_active = 0;
  logic [7:0]  m_rdata = 0;
  logic [31:0] m_acc = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_bit(input bit low);
    mq.push_back(1 | (int'(low) << 1));
    mq.push_back((int'(low) << 1) | 4 | 8);
  endtask

  task automatic model_update(input bit scl_l, input bit sda_l);
    int nreq, seg, p;
    bit was_busy, was_idle, s_irq, s_ov, s_bf, s_stop, s_wc;
    nreq = int'(start_r) + int'(wr_r) + int'(rcv_r) + int'(ack_r) + int'(stop_r);
    was_busy = m_busy; was_idle = m_idle; p = int'(div_r) + 1;
    s_irq = 0; s_ov = 0; s_bf = 0; s_stop = 0; s_wc = 0;
    if (was_busy) begin
      seg = mq[0];
      if (!seg[2] || scl_l) m_cnt++;
      if (m_cnt == p) begin
        m_cnt = 0;
        if (seg[3]) m_acc = (m_acc << 1) | 32'(sda_l);
        void'(mq.pop_front());
        if (mq.size() == 0) begin
          m_busy = 0; m_active = 0; s_irq = 1; m_sda_hold = seg[1];
          case (m_kind)
            1: m_nack = m_acc[0];
            2: if (m_bf) s_ov = 1; else begin m_rdata = m_acc[7:0]; s_bf = 1; end
            4: begin m_idle = 1; s_stop = 1; end
            default: ;
          endcase
        end
      end
    end
    if (nreq > 0) begin
      if (nreq == 1 && !was_busy && (start_r ? was_idle : !was_idle)) begin
        m_busy = 1; m_cnt = 0; m_acc = 0;
        if (start_r) begin
          m_kind = 0; m_idle = 0; mq.push_back(2); mq.push_back(3);
        end else if (wr_r) begin
          m_kind = 1;
          for (int k = 7; k >= 0; k--) push_bit(!wdata_r[k]);
          push_bit(0);
        end else if (rcv_r) begin
          m_kind = 2;
          for (int k = 0; k < 8; k++) push_bit(0);
        end else if (ack_r) begin
          m_kind = 3; push_bit(!ack_val_r);
        end else begin
          m_kind = 4; mq.push_back(3); mq.push_back(2 | 4); mq.push_back(0);
        end
        m_active = 5'b1 << m_kind;
      end else s_wc = 1;
    end
    m_irq  = s_irq  ? 1 : (clr_r ? 0 : m_irq);
    m_ovf  = s_ov   ? 1 : (clr_r ? 0 : m_ovf);
    m_wcol = s_wc   ? 1 : (clr_r ? 0 : m_wcol);
    m_stop = s_stop ? 1 : (clr_r ? 0 : m_stop);
    m_bf   = s_bf   ? 1 : (rd_r  ? 0 : m_bf);
  endtask

  task automatic compare();
    logic [20:0] act, exp;
    bit e_scl, e_sda;
    e_scl = m_busy ? mq[0][0] : !m_idle;
    e_sda = m_busy ? mq[0][1] : (m_idle ? 1'b0 : m_sda_hold);
    act = {scl_oe_w, sda_oe_w, irq_w, bf_w, ovf_w, stop_w, wcol_w, nack_w, active_w, rdata_w};
    exp = {e_scl, e_sda, m_irq, m_bf, m_ovf, m_stop, m_wcol, m_nack, m_active, m_rdata};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: cycle outputs actual=%h expected=%h", cur_req, act, exp);
    end
  endtask

  task automatic step();
    bit scl_l, sda_l;
    if (sl_stretch_n > 0 && !scl_oe_w && prev_scl_oe) begin
      stretch_left = sl_stretch_n; sl_stretch_n = 0;
    end
    sl_scl_hold = (stretch_left > 0);
    if (stretch_left > 0) stretch_left--;
    scl_l = !(scl_oe_w || sl_scl_hold);
    if (scl_l && !prev_line && sl_rc < 9) sl_rc++;
    if (!scl_l) sl_sda_low = sl_armed && sl_rc < 9 && !sl_pat[8-sl_rc];
    sda_l = !(sda_oe_w || sl_sda_low);
    model_update(scl_l, sda_l);
    prev_line = scl_l; prev_scl_oe = scl_oe_w;
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  // mask bits: 0 start, 1 wr, 2 rcv, 3 ack, 4 stop, 5 rd, 6 clr
  task automatic pulse(input logic [6:0] m, input logic [7:0] d, input bit av);
    {clr_r, rd_r, stop_r, ack_r, rcv_r, wr_r, start_r} = m;
    wdata_r = d; ack_val_r = av;
    step();
    {clr_r, rd_r, stop_r, ack_r, rcv_r, wr_r, start_r} = '0;
  endtask

  task automatic run_done();
    for (int g = 0; g < 5000 && m_busy; g++) step();
  endtask

  task automatic arm(input logic [8:0] pat, input int stretch);
    sl_pat = pat; sl_rc = 0; sl_armed = 1; sl_stretch_n = stretch;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R9"; compare();
    chk("R9", {scl_oe_w, sda_oe_w, irq_w, active_w}, 0);

    cur_req = "R1"; pulse(7'b0000001, 0, 0); run_done();
    chk("R1", {irq_w, scl_oe_w, sda_oe_w}, 3'b111);
    cur_req = "R9"; pulse(7'b1000000, 0, 0);
    chk("R9", irq_w, 0);

    cur_req = "R2"; arm(9'h1FE, 0); pulse(7'b0000010, 8'hA5, 0); run_done();
    chk("R2", nack_w, 0);
    chk("R2", irq_w, 1);

    cur_req = "R7"; arm(9'h1FF, 5); pulse(7'b0000010, 8'h3C, 0); run_done();
    chk("R7", nack_w, 1);

    cur_req = "R3"; arm({8'h96, 1'b1}, 0); pulse(7'b0000100, 0, 0); run_done();
    chk("R3", rdata_w, 8'h96);
    chk("R3", bf_w, 1);

    cur_req = "R5"; pulse(7'b0001000, 0, 0); run_done();
    chk("R5", sda_oe_w, 1);

    cur_req = "R4"; arm({8'h5A, 1'b1}, 0); pulse(7'b0000100, 0, 0); run_done();
    chk("R4", ovf_w, 1);
    chk("R4", rdata_w, 8'h96);

    cur_req = "R5"; pulse(7'b0001000, 0, 1); run_done();
    chk("R5", sda_oe_w, 0);

    cur_req = "R8"; pulse(7'b1000000, 0, 0); pulse(7'b0000001, 0, 0);
    chk("R8", {wcol_w, active_w}, 6'b100000);
    pulse(7'b1000000, 0, 0); pulse(7'b0001100, 0, 0);
    chk("R8", {wcol_w, active_w}, 6'b100000);
    pulse(7'b1000000, 0, 0);
    arm(9'h1FE, 0); pulse(7'b0000010, 8'h0F, 0); step();
    pulse(7'b0000100, 0, 0);
    chk("R8", {wcol_w, active_w}, 6'b100010);
    run_done();

    cur_req = "R9"; pulse(7'b0100000, 0, 0);
    chk("R9", bf_w, 0);
    pulse(7'b1000000, 0, 0);
    chk("R9", {ovf_w, wcol_w, irq_w}, 0);

    cur_req = "R6"; sl_armed = 0; pulse(7'b0010000, 0, 0); run_done();
    chk("R6", {stop_w, irq_w, scl_oe_w, sda_oe_w}, 4'b1100);

    cur_req = "R7"; pulse(7'b1000000, 0, 0); div_r = 8'd0; step();
    pulse(7'b0000001, 0, 0); run_done();
    arm(9'h1FE, 3); pulse(7'b0000010, 8'h81, 0); run_done();
    chk("R7", nack_w, 0);
    cur_req = "R10"; sl_armed = 0; pulse(7'b0010000, 0, 0); run_done();
    chk("R10", active_w, 0);
    repeat (3) step();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule